// File: doc/BRIEF.md
# PS/2 Keyboard Receive Controller

This block takes in serial frames from a PS/2-style keyboard over its two-wire clock and data lines and places each good byte in a buffer register. Both lines pass through a multi-flop synchronizer. Data is sampled on each falling edge of the keyboard clock. A frame is eleven bits long: a start bit of 0, eight data bits sent least significant bit first, an odd-parity bit and a stop bit.

A control/status word holds several fields. It holds the enable, the interrupt enable and a mode select. It also holds the live levels of both lines, the stop bit of the last frame, a parity-error flag and a dual-purpose event flag. In buffer mode the event flag means "byte received". In edge mode it means "clock falling edge seen".

Both flags are sticky. Each clears only through a read that sees it at 1, followed by a write of 0. A programmable idle timeout drops a partial frame so that the next frame starts cleanly. Software reaches the control word and the buffer through a simple synchronous register port. The interrupt output is the event flag gated by the interrupt enable.

Top module: `ps2_rx_ctrl`

## Requirements
- R1: After reset, control word bits 5..0 read 0, the buffer reads 0x00 and irq is 0. Control word layout: bit0 enable, bit1 interrupt enable, bit2 mode select (1 = buffer mode, 0 = edge mode), bit3 event flag, bit4 parity error, bit5 last stop bit, bit6 clock level, bit7 data level. Address 0 selects the control word and address 1 selects the buffer.
- R2: While enable is 0, keyboard clock edges and frames have no effect: the flags, the stop bit and the buffer keep their values.
- R3: Bits 6 and 7 follow the synchronized levels of the keyboard clock line and data line.
- R4: In buffer mode, a frame with correct odd parity loads its byte into the buffer and sets the event flag. The frame is a start bit of 0, then data bits LSB first, then parity, then stop.
- R5: A frame whose parity is not odd sets the parity-error flag. It leaves the buffer and the event flag unchanged.
- R6: Bit 5 holds the stop bit value of the most recently completed frame.
- R7: In edge mode, every falling edge of the keyboard clock sets the event flag.
- R8: A sticky flag clears only when a write of 0 to its bit follows a read of the control word that returned it as 1. A write of 0 without such a read, or a write of 1, leaves the flag set.
- R9: A new setting event takes priority over a clear. A setting event also cancels any earlier read, so a following write of 0 leaves the flag set.
- R10: irq equals the event flag ANDed with the interrupt enable, one cycle later.
- R11: If no clock falling edge arrives within IDLE_TO cycles during a partial frame, the bit position resets, and the next full frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kb_dat_i | input | 1 | Keyboard data line, asynchronous |
| reg_addr | input | 1 | Register select: 0 = control word, 1 = buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, data valid the next cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| buf_byte | output | 8 | Current buffer byte |
| status_o | output | 8 | Current control/status word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that read and write strobes never occur in the same cycle. They also assume the keyboard clock stays in each level for longer than the synchronizer depth, so that every falling edge is seen once. The bench issues one register access at a time, on the falling system clock edge. It holds each keyboard clock phase for eight system cycles, well inside the reduced idle timeout of 40 cycles. The only exception is the timeout scenario, which stalls on purpose for 100 cycles in the middle of a frame.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned DW         = 8;
  localparam int unsigned FRAME_BITS = 11;
  localparam int unsigned CW         = $clog2(FRAME_BITS);

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_BUF  = 1'b1
  } reg_sel_e;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_IE   = 1;
  localparam int unsigned B_SEL  = 2;
  localparam int unsigned B_FLAG = 3;
  localparam int unsigned B_PERR = 4;
  localparam int unsigned B_STOP = 5;
  localparam int unsigned B_CLK  = 6;
  localparam int unsigned B_DAT  = 7;
endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_raw,
  input  logic dat_raw,
  output logic clk_lvl,
  output logic dat_lvl,
  output logic clk_fall
);
  logic [STAGES-1:0] c_sh, d_sh;
  logic              c_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_sh   <= '1;
      d_sh   <= '1;
      c_prev <= 1'b1;
    end else begin
      c_sh   <= {c_sh[STAGES-2:0], clk_raw};
      d_sh   <= {d_sh[STAGES-2:0], dat_raw};
      c_prev <= c_sh[STAGES-1];
    end
  end

  assign clk_lvl  = c_sh[STAGES-1];
  assign dat_lvl  = d_sh[STAGES-1];
  assign clk_fall = c_prev & ~c_sh[STAGES-1];
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
  import ps2_rx_pkg::*;
#(
  parameter int unsigned IDLE_TO = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          fall,
  input  logic          dat,
  output logic          done,
  output logic [DW-1:0] byte_o,
  output logic          par_ok,
  output logic          stop_o
);
  localparam int unsigned TW = $clog2(IDLE_TO + 1);
  localparam logic [CW-1:0] LAST_DATA = CW'(DW);
  localparam logic [CW-1:0] PAR_POS   = CW'(DW + 1);
  localparam logic [TW-1:0] IDLE_MAX  = TW'(IDLE_TO - 1);

  logic [CW-1:0] pos;
  logic [DW-1:0] sh;
  logic          par_b;
  logic [TW-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      sh     <= '0;
      par_b  <= 1'b0;
      idle   <= '0;
      done   <= 1'b0;
      byte_o <= '0;
      par_ok <= 1'b0;
      stop_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        pos  <= '0;
        idle <= '0;
      end else if (fall) begin
        idle <= '0;
        if (pos == '0) begin
          if (!dat) pos <= CW'(1);
        end else if (pos <= LAST_DATA) begin
          sh  <= {dat, sh[DW-1:1]};
          pos <= pos + CW'(1);
        end else if (pos == PAR_POS) begin
          par_b <= dat;
          pos   <= pos + CW'(1);
        end else begin
          done   <= 1'b1;
          byte_o <= sh;
          par_ok <= ^{sh, par_b};
          stop_o <= dat;
          pos    <= '0;
        end
      end else if (pos != '0) begin
        if (idle == IDLE_MAX) begin
          pos  <= '0;
          idle <= '0;
        end else begin
          idle <= idle + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ps2_rx_regs.sv
module ps2_rx_regs
  import ps2_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_byte,
  input  logic          frame_par_ok,
  input  logic          frame_stop,
  input  logic          edge_ev,
  input  logic          clk_lvl,
  input  logic          dat_lvl,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] buf_q,
  output logic [DW-1:0] status,
  output logic          irq,
  output logic          en,
  output logic          flag_set,
  output logic          perr_set
);
  logic ie, sel, flag, perr, stop_q, flag_arm, perr_arm;
  logic rd_ctrl, wr_ctrl, flag_clr, perr_clr;

  assign rd_ctrl  = rd && (addr == REG_CTRL);
  assign wr_ctrl  = wr && (addr == REG_CTRL);
  assign flag_set = sel ? (frame_done && frame_par_ok) : edge_ev;
  assign perr_set = frame_done && !frame_par_ok;
  assign flag_clr = wr_ctrl && !wdata[B_FLAG] && flag_arm;
  assign perr_clr = wr_ctrl && !wdata[B_PERR] && perr_arm;

  assign status = {dat_lvl, clk_lvl, stop_q, perr, flag, sel, ie, en};

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; ie <= 1'b0; sel <= 1'b0;
      flag <= 1'b0; flag_arm <= 1'b0;
      perr <= 1'b0; perr_arm <= 1'b0;
      stop_q <= 1'b0; buf_q <= '0; rdata <= '0; irq <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en  <= wdata[B_EN];
        ie  <= wdata[B_IE];
        sel <= wdata[B_SEL];
      end
      if (flag_set) begin
        flag <= 1'b1; flag_arm <= 1'b0;
      end else if (flag_clr) begin
        flag <= 1'b0; flag_arm <= 1'b0;
      end else if (rd_ctrl && flag) begin
        flag_arm <= 1'b1;
      end
      if (perr_set) begin
        perr <= 1'b1; perr_arm <= 1'b0;
      end else if (perr_clr) begin
        perr <= 1'b0; perr_arm <= 1'b0;
      end else if (rd_ctrl && perr) begin
        perr_arm <= 1'b1;
      end
      if (frame_done) stop_q <= frame_stop;
      if (frame_done && frame_par_ok) buf_q <= frame_byte;
      if (rd) rdata <= (addr == REG_CTRL) ? status : buf_q;
      irq <= flag & ie;
    end
  end
endmodule

// File: rtl/ps2_rx_ctrl.sv
module ps2_rx_ctrl
  import ps2_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_TO     = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kb_clk_i,
  input  logic          kb_dat_i,
  input  logic          reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] buf_byte,
  output logic [DW-1:0] status_o,
  output logic          irq
);
  logic          clk_lvl, dat_lvl, clk_fall, en, edge_ev;
  logic          frame_done, frame_par_ok, frame_stop;
  logic [DW-1:0] frame_byte;
  logic          flag_set, perr_set;

  ps2_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .clk_raw(kb_clk_i), .dat_raw(kb_dat_i),
    .clk_lvl(clk_lvl), .dat_lvl(dat_lvl), .clk_fall(clk_fall)
  );

  assign edge_ev = clk_fall & en;

  ps2_rx_frame #(.IDLE_TO(IDLE_TO)) u_frame (
    .clk(clk), .rst(rst), .en(en), .fall(clk_fall), .dat(dat_lvl),
    .done(frame_done), .byte_o(frame_byte), .par_ok(frame_par_ok),
    .stop_o(frame_stop)
  );

  ps2_rx_regs u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .frame_done(frame_done), .frame_byte(frame_byte),
    .frame_par_ok(frame_par_ok), .frame_stop(frame_stop),
    .edge_ev(edge_ev), .clk_lvl(clk_lvl), .dat_lvl(dat_lvl),
    .rdata(reg_rdata), .buf_q(buf_byte), .status(status_o), .irq(irq),
    .en(en), .flag_set(flag_set), .perr_set(perr_set)
  );
endmodule

// File: rtl/ps2_rx_chk.sv
module ps2_rx_chk
  import ps2_rx_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          frame_done,
  input logic          flag_set,
  input logic          perr_set,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] status_o,
  input logic [DW-1:0] buf_byte,
  input logic          irq
);
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(status_o[B_FLAG] && status_o[B_IE])));

  // R9
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    flag_set |=> status_o[B_FLAG]);

  // R5
  perr_set_chk: assert property (@(posedge clk) disable iff (rst)
    perr_set |=> status_o[B_PERR]);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[B_FLAG] && !(reg_wr && reg_addr == REG_CTRL && !reg_wdata[B_FLAG]))
      |=> status_o[B_FLAG]);

  // R2
  idle_no_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !frame_done);

  // R4
  buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(buf_byte));
endmodule

bind ps2_rx_ctrl ps2_rx_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .frame_done(frame_done),
  .flag_set(flag_set), .perr_set(perr_set), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_o(status_o),
  .buf_byte(buf_byte), .irq(irq)
);

// File: tb/ps2_rx_ctrl_tb_top.sv
`timescale 1ns/1ps
module ps2_rx_ctrl_tb_top;
  logic       clk = 0, rst = 1;
  logic       kb_clk = 1, kb_dat = 1;
  logic       reg_addr = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata, buf_byte, status_o;
  logic       irq;
  int         total = 0, bad = 0;
  logic [7:0] d;

  always #2 clk = ~clk;

  ps2_rx_ctrl #(.SYNC_STAGES(2), .IDLE_TO(40)) dut_i (
    .clk(clk), .rst(rst), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_byte(buf_byte),
    .status_o(status_o), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic kb_bit(input logic b);
    kb_dat = b;
    repeat (4) @(negedge clk);
    kb_clk = 0;
    repeat (8) @(negedge clk);
    kb_clk = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] v, input bit bad_par, input logic stopv);
    kb_bit(1'b0);
    for (int i = 0; i < 8; i++) kb_bit(v[i]);
    kb_bit(bad_par ? ^v : ~^v);
    kb_bit(stopv);
    kb_dat = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    rd(1'b0, d);
    check(d[5:0] == 6'h00, "R1 ctrl", d, 0);
    check(d[7:6] == 2'b11, "R3 idle levels", d[7:6], 3);
    check(buf_byte == 8'h00 && irq == 1'b0, "R1 buf/irq", {irq, buf_byte}, 0);
  endtask

  task automatic t_disabled();
    send_frame(8'h3C, 0, 1'b1);
    check(status_o[5:0] == 6'h00, "R2 status", status_o, 0);
    check(buf_byte == 8'h00, "R2 buf", buf_byte, 0);
  endtask

  task automatic t_levels();
    kb_dat = 0; kb_clk = 1;
    repeat (5) @(negedge clk);
    check(status_o[7:6] == 2'b01, "R3 dat low", status_o[7:6], 1);
    kb_dat = 1;
    repeat (5) @(negedge clk);
    check(status_o[7:6] == 2'b11, "R3 dat high", status_o[7:6], 3);
  endtask

  task automatic t_rx_good();
    wr(1'b0, 8'h07);
    send_frame(8'hA5, 0, 1'b1);
    rd(1'b1, d);
    check(d == 8'hA5, "R4 buffer", d, 8'hA5);
    check(status_o[3] && !status_o[4], "R4 flag", status_o, 8'h08);
    check(status_o[5] == 1'b1, "R6 stop1", status_o[5], 1);
    check(irq == 1'b1, "R10 irq on", irq, 1);
    wr(1'b0, 8'h07);
    check(status_o[3] == 1'b1, "R8 no read", status_o[3], 1);
    rd(1'b0, d);
    wr(1'b0, 8'h0F);
    check(status_o[3] == 1'b1, "R8 write1", status_o[3], 1);
    wr(1'b0, 8'h07);
    check(status_o[3] == 1'b0, "R8 cleared", status_o[3], 0);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R10 irq off", irq, 0);
  endtask

  task automatic t_stop0();
    send_frame(8'h5A, 0, 1'b0);
    check(buf_byte == 8'h5A, "R4 buffer2", buf_byte, 8'h5A);
    check(status_o[5] == 1'b0, "R6 stop0", status_o[5], 0);
  endtask

  task automatic t_parity();
    rd(1'b0, d); wr(1'b0, 8'h07);
    send_frame(8'h11, 1, 1'b1);
    check(status_o[4] == 1'b1, "R5 perr", status_o[4], 1);
    check(status_o[3] == 1'b0, "R5 no flag", status_o[3], 0);
    check(buf_byte == 8'h5A, "R5 buf kept", buf_byte, 8'h5A);
    check(status_o[5] == 1'b1, "R6 stop after perr", status_o[5], 1);
    rd(1'b0, d); wr(1'b0, 8'h07);
    check(status_o[4] == 1'b0, "R8 perr cleared", status_o[4], 0);
  endtask

  task automatic t_timeout();
    kb_bit(1'b0); kb_bit(1'b1); kb_bit(1'b1); kb_bit(1'b0);
    repeat (100) @(negedge clk);
    send_frame(8'hC3, 0, 1'b1);
    check(buf_byte == 8'hC3, "R11 resync", buf_byte, 8'hC3);
    check(status_o[4] == 1'b0, "R11 no perr", status_o[4], 0);
    rd(1'b0, d); wr(1'b0, 8'h07);
  endtask

  task automatic t_edge();
    wr(1'b0, 8'h01);
    kb_bit(1'b1);
    rd(1'b0, d);
    check(d[3] == 1'b1, "R7 edge flag", d[3], 1);
    check(irq == 1'b0, "R10 ie off", irq, 0);
    kb_bit(1'b1);
    wr(1'b0, 8'h01);
    check(status_o[3] == 1'b1, "R9 set cancels read", status_o[3], 1);
    rd(1'b0, d); wr(1'b0, 8'h01);
    check(status_o[3] == 1'b0, "R9 clear after reread", status_o[3], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_levels();
    t_rx_good();
    t_stop0();
    t_parity();
    t_timeout();
    t_edge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule